// File: doc/BRIEF.md
# Exclusive Store Unit with Local Reservation Monitor

This unit runs the two halves of a load-linked / store-conditional pair for 32-bit and 64-bit elements. A load-exclusive request records an address and a byte length in a single local reservation monitor. It produces no memory traffic.

A later store-exclusive compares its own byte range with the recorded one. When the range is fully covered, the unit issues a memory write over a valid/ready channel and then reports success. When it is not covered, the unit writes nothing and reports failure at once. In both cases the result reaches a register write port as a 32-bit value whose only possibly-set bit is bit 0.

The unit takes register indices that have already been decoded, along with the register operand values and the stack pointer. From these it picks the base address and applies a 16-byte alignment rule when the base is the stack pointer. It also settles what happens when the status destination index collides with the data index or with the base index. A static two-bit mode input selects the outcome of a collision.

Top module: `xstore_unit`

## Requirements
- R1: The size input `op_size` gives the byte count 1 << `op_size`: 2 means 4 bytes and 3 means 8 bytes. `mem_wr_bytes` carries that count. `mem_wr_data` keeps only the low count×8 bits of the data operand and has every higher bit at zero.
- R2: An accepted load-exclusive (`op_is_store`=0) records its base address and byte count in the monitor. It raises no memory write, no status write and no fault.
- R3: An accepted store-exclusive whose byte range [addr, addr+count-1] lies wholly inside the recorded range raises `mem_wr_valid` in the cycle after acceptance. Status 0 is then written in the cycle after the write handshake.
- R4: A store-exclusive whose range is not wholly covered, or that finds the monitor empty, raises no memory write. It writes status 1 in the cycle right after acceptance.
- R5: A status write places the status bit in bit 0 of `st_val` with bits 31..1 at zero. `st_idx` equals the status index `op_rs` of that store.
- R6: Every store-exclusive that reaches the monitor check empties the monitor, whether it passes or fails. A pulse on `mon_clear` also empties it. When `mon_clear` and a load-exclusive are accepted in the same cycle, the monitor ends up empty.
- R7: A base index of 31 selects `sp_value` as the base address. If `sp_value` is not a multiple of 16, `fault_align` pulses for one cycle. No memory write and no status write follow, and the monitor keeps its contents.
- R8: For a store where `op_rs` equals `op_rt`, the outcome depends on `overlap_mode`. Mode 0 stores all-zero data. Mode 1 pulses `fault_undef` and does nothing else. Modes 2 and 3 do nothing. In modes 1 to 3 the monitor is left untouched.
- R9: For a store where `op_rs` equals `op_rn` and `op_rn` is not 31, the same mode choice applies. In mode 0 the address becomes zero. When the status and base indices are both 31, no collision is taken.
- R10: During a memory write, `mem_wr_release` is 1 and `mem_wr_tagchk` is 1 exactly when the base index is not 31.
- R11: `mem_wr_valid`, `mem_wr_addr` and `mem_wr_data` stay steady until `mem_wr_ready` is seen. `busy` is high while a write is pending, and requests are accepted only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request present this cycle |
| op_is_store | input | 1 | 1 = store-exclusive, 0 = load-exclusive |
| op_size | input | 2 | Element size code |
| op_rs | input | 5 | Status destination index |
| op_rt | input | 5 | Data register index |
| op_rn | input | 5 | Base register index (31 = stack pointer) |
| rn_data | input | 64 | Base register value |
| rt_data | input | 64 | Data register value |
| sp_value | input | 64 | Stack pointer value |
| overlap_mode | input | 2 | Collision outcome: 0 zero, 1 fault, 2/3 no-op |
| mon_clear | input | 1 | Empties the reservation monitor |
| busy | output | 1 | Write pending, request not accepted |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | 64 | Write address |
| mem_wr_data | output | 64 | Write data, masked to element |
| mem_wr_bytes | output | 4 | Write byte count |
| mem_wr_release | output | 1 | Release ordering attribute |
| mem_wr_tagchk | output | 1 | Tag check requested |
| st_we | output | 1 | Status register write strobe |
| st_idx | output | 5 | Status register index |
| st_val | output | 32 | Zero-extended status |
| fault_align | output | 1 | Stack pointer misalignment fault pulse |
| fault_undef | output | 1 | Undefined-instruction fault pulse |

## Verification
The bench targets partial coverage, where a 4-byte reservation meets an 8-byte store or a word store lands inside a doubleword reservation. A range compare that checks only the start address would accept the first case wrongly. It also checks that a misaligned stack pointer, an undefined-fault collision and a no-op collision all leave the reservation intact. A design that emptied the monitor on those paths would fail the store that follows. Further cases cover zero substitution of data and address in mode 0, the case where status and base are both index 31 and no collision may be taken, a clear event arriving with a load, and the timing of the status write around a stalled write handshake.

// File: rtl/xsu_pkg.sv
package xsu_pkg;

    typedef enum logic [1:0] {
        OVL_ZERO  = 2'd0,
        OVL_UNDEF = 2'd1,
        OVL_NOP   = 2'd2,
        OVL_NOP3  = 2'd3
    } ovl_mode_e;

    typedef enum logic {
        XS_IDLE  = 1'b0,
        XS_WRITE = 1'b1
    } xs_state_e;

    typedef struct packed {
        logic undef;
        logic noop;
        logic sp_fault;
        logic tagchk;
    } dec_flags_t;

    function automatic int unsigned bytes_w(input int unsigned data_w);
        return $clog2(data_w / 8) + 1;
    endfunction

endpackage

// File: rtl/xsu_decode.sv
module xsu_decode
    import xsu_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 64,
    parameter int IDX_W    = 5,
    parameter int SP_ALIGN = 16
) (
    input  logic                         is_store,
    input  logic [1:0]                   size,
    input  logic [IDX_W-1:0]             rs,
    input  logic [IDX_W-1:0]             rt,
    input  logic [IDX_W-1:0]             rn,
    input  logic [ADDR_W-1:0]            rn_data,
    input  logic [DATA_W-1:0]            rt_data,
    input  logic [ADDR_W-1:0]            sp_value,
    input  logic [1:0]                   mode,
    output logic [ADDR_W-1:0]            eff_addr,
    output logic [DATA_W-1:0]            eff_data,
    output logic [bytes_w(DATA_W)-1:0]   eff_bytes,
    output dec_flags_t                   flags
);
    localparam int BYTES_W    = bytes_w(DATA_W);
    localparam int NBYTES     = DATA_W / 8;
    localparam int ALIGN_BITS = $clog2(SP_ALIGN);
    localparam logic [IDX_W-1:0] SP_IDX = {IDX_W{1'b1}};

    ovl_mode_e   omode;
    logic        is_sp;
    logic        data_clash;
    logic        base_clash;
    logic        clash;
    logic [ADDR_W-1:0] base;
    logic [DATA_W-1:0] masked;

    always_comb begin
        omode      = ovl_mode_e'(mode);
        is_sp      = (rn == SP_IDX);
        base       = is_sp ? sp_value : rn_data;
        eff_bytes  = BYTES_W'(1) << size;
        for (int i = 0; i < NBYTES; i++) begin
            masked[i*8 +: 8] = (i < int'(eff_bytes)) ? rt_data[i*8 +: 8] : 8'h00;
        end
        data_clash = is_store && (rs == rt);
        base_clash = is_store && (rs == rn) && !is_sp;
        clash      = data_clash || base_clash;

        flags.undef    = clash && (omode == OVL_UNDEF);
        flags.noop     = clash && (omode == OVL_NOP || omode == OVL_NOP3);
        flags.sp_fault = is_sp && (|sp_value[ALIGN_BITS-1:0])
                         && !flags.undef && !flags.noop;
        flags.tagchk   = !is_sp;

        eff_addr = (base_clash && omode == OVL_ZERO) ? '0 : base;
        eff_data = (data_clash && omode == OVL_ZERO) ? '0 : masked;
    end

    always_comb begin
        assert (!(flags.undef && flags.noop)); // R8
    end

endmodule

// File: rtl/xsu_monitor.sv
module xsu_monitor #(
    parameter int ADDR_W  = 64,
    parameter int BYTES_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm,
    input  logic [ADDR_W-1:0]  arm_addr,
    input  logic [BYTES_W-1:0] arm_bytes,
    input  logic               clear_evt,
    input  logic               consume,
    input  logic [ADDR_W-1:0]  chk_addr,
    input  logic [BYTES_W-1:0] chk_bytes,
    output logic               hit
);
    localparam int EXT_W = ADDR_W + 1;

    logic               armed;
    logic [ADDR_W-1:0]  res_base;
    logic [BYTES_W-1:0] res_len;
    logic [EXT_W-1:0]   chk_end;
    logic [EXT_W-1:0]   res_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            res_base <= '0;
            res_len  <= '0;
        end else if (clear_evt) begin
            armed    <= 1'b0;
        end else if (arm) begin
            armed    <= 1'b1;
            res_base <= arm_addr;
            res_len  <= arm_bytes;
        end else if (consume) begin
            armed    <= 1'b0;
        end
    end

    always_comb begin
        chk_end = {1'b0, chk_addr} + {{(EXT_W-BYTES_W){1'b0}}, chk_bytes};
        res_end = {1'b0, res_base} + {{(EXT_W-BYTES_W){1'b0}}, res_len};
        hit     = armed && (chk_addr >= res_base) && (chk_end <= res_end);
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clear_evt |=> !hit); // R6
    AST_CONSUME_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (consume && !arm) |=> !hit); // R6

endmodule

// File: rtl/xstore_unit.sv
module xstore_unit
    import xsu_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 64,
    parameter int IDX_W    = 5,
    parameter int STATUS_W = 32,
    parameter int SP_ALIGN = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid,
    input  logic                 op_is_store,
    input  logic [1:0]           op_size,
    input  logic [IDX_W-1:0]     op_rs,
    input  logic [IDX_W-1:0]     op_rt,
    input  logic [IDX_W-1:0]     op_rn,
    input  logic [ADDR_W-1:0]    rn_data,
    input  logic [DATA_W-1:0]    rt_data,
    input  logic [ADDR_W-1:0]    sp_value,
    input  logic [1:0]           overlap_mode,
    input  logic                 mon_clear,
    output logic                 busy,
    output logic                 mem_wr_valid,
    input  logic                 mem_wr_ready,
    output logic [ADDR_W-1:0]    mem_wr_addr,
    output logic [DATA_W-1:0]    mem_wr_data,
    output logic [$clog2(DATA_W/8):0] mem_wr_bytes,
    output logic                 mem_wr_release,
    output logic                 mem_wr_tagchk,
    output logic                 st_we,
    output logic [IDX_W-1:0]     st_idx,
    output logic [STATUS_W-1:0]  st_val,
    output logic                 fault_align,
    output logic                 fault_undef
);
    localparam int BYTES_W = bytes_w(DATA_W);

    xs_state_e           state;
    logic                accept;
    logic                store_go;
    logic                load_go;
    logic                mon_hit;
    logic [ADDR_W-1:0]   dec_addr;
    logic [DATA_W-1:0]   dec_data;
    logic [BYTES_W-1:0]  dec_bytes;
    dec_flags_t          dec_flags;

    logic [ADDR_W-1:0]   wr_addr_q;
    logic [DATA_W-1:0]   wr_data_q;
    logic [BYTES_W-1:0]  wr_bytes_q;
    logic                wr_tag_q;
    logic [IDX_W-1:0]    sidx_q;
    logic                st_we_q;
    logic [IDX_W-1:0]    st_idx_q;
    logic                st_bit_q;
    logic                fa_q;
    logic                fu_q;

    xsu_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .SP_ALIGN (SP_ALIGN)
    ) u_decode (
        .is_store  (op_is_store),
        .size      (op_size),
        .rs        (op_rs),
        .rt        (op_rt),
        .rn        (op_rn),
        .rn_data   (rn_data),
        .rt_data   (rt_data),
        .sp_value  (sp_value),
        .mode      (overlap_mode),
        .eff_addr  (dec_addr),
        .eff_data  (dec_data),
        .eff_bytes (dec_bytes),
        .flags     (dec_flags)
    );

    always_comb begin
        accept   = op_valid && (state == XS_IDLE);
        load_go  = accept && !op_is_store && !dec_flags.sp_fault;
        store_go = accept && op_is_store && !dec_flags.undef
                   && !dec_flags.noop && !dec_flags.sp_fault;
    end

    xsu_monitor #(
        .ADDR_W  (ADDR_W),
        .BYTES_W (BYTES_W)
    ) u_monitor (
        .clk       (clk),
        .rst       (rst),
        .arm       (load_go),
        .arm_addr  (dec_addr),
        .arm_bytes (dec_bytes),
        .clear_evt (mon_clear),
        .consume   (store_go),
        .chk_addr  (dec_addr),
        .chk_bytes (dec_bytes),
        .hit       (mon_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= XS_IDLE;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
            wr_bytes_q <= '0;
            wr_tag_q   <= 1'b0;
            sidx_q     <= '0;
            st_we_q    <= 1'b0;
            st_idx_q   <= '0;
            st_bit_q   <= 1'b0;
            fa_q       <= 1'b0;
            fu_q       <= 1'b0;
        end else begin
            st_we_q <= 1'b0;
            fa_q    <= accept && dec_flags.sp_fault;
            fu_q    <= accept && dec_flags.undef;
            case (state)
                XS_IDLE: begin
                    if (store_go) begin
                        sidx_q <= op_rs;
                        if (mon_hit) begin
                            state      <= XS_WRITE;
                            wr_addr_q  <= dec_addr;
                            wr_data_q  <= dec_data;
                            wr_bytes_q <= dec_bytes;
                            wr_tag_q   <= dec_flags.tagchk;
                        end else begin
                            st_we_q  <= 1'b1;
                            st_idx_q <= op_rs;
                            st_bit_q <= 1'b1;
                        end
                    end
                end
                XS_WRITE: begin
                    if (mem_wr_ready) begin
                        state    <= XS_IDLE;
                        st_we_q  <= 1'b1;
                        st_idx_q <= sidx_q;
                        st_bit_q <= 1'b0;
                    end
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    always_comb begin
        busy           = (state == XS_WRITE);
        mem_wr_valid   = (state == XS_WRITE);
        mem_wr_addr    = wr_addr_q;
        mem_wr_data    = wr_data_q;
        mem_wr_bytes   = wr_bytes_q;
        mem_wr_release = 1'b1;
        mem_wr_tagchk  = wr_tag_q;
        st_we          = st_we_q;
        st_idx         = st_idx_q;
        st_val         = {{(STATUS_W-1){1'b0}}, st_bit_q};
        fault_align    = fa_q;
        fault_undef    = fu_q;
    end

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R11
    AST_STATUS_AFTER_HS: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && mem_wr_ready) |=> (st_we && st_val == '0)); // R3
    AST_STATUS_ZEXT: assert property (@(posedge clk) disable iff (rst)
        st_we |-> (st_val[STATUS_W-1:1] == '0)); // R5
    AST_ALIGN_SILENT: assert property (@(posedge clk) disable iff (rst)
        fault_align |-> (!mem_wr_valid && !st_we)); // R7
    AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (rst)
        fault_undef |-> (!mem_wr_valid && !st_we && !fault_align)); // R8
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_wr_ready) |=> (busy && !st_we)); // R11

endmodule

// File: tb/tb_xstore_unit.sv
`timescale 1ns/1ps
module tb_xstore_unit;

    typedef struct packed {
        logic        st;
        logic [1:0]  sz;
        logic [4:0]  s;
        logic [4:0]  t;
        logic [4:0]  n;
        logic [63:0] base;
        logic [63:0] data;
        logic [63:0] sp;
        logic [1:0]  mode;
        logic [1:0]  dly;
        logic        ewr;
        logic [63:0] eaddr;
        logic [63:0] edata;
        logic        est;
        logic        estv;
        logic        efa;
        logic        efu;
    } vec_t;

    localparam logic [63:0] D1 = 64'h1122_3344_5566_7788;
    localparam logic [63:0] D2 = 64'hAAAA_BBBB_CCCC_DDDD;
    localparam logic [63:0] SPA = 64'h1000;
    localparam int NV = 19;

    localparam vec_t VECS [NV] = '{
        '{1'b0,2'd3,5'd0,5'd0,5'd1, 64'h100,64'h0,SPA,2'd0,2'd0, 1'b0,64'h0,64'h0, 1'b0,1'b0,1'b0,1'b0},
        '{1'b1,2'd3,5'd2,5'd3,5'd1, 64'h100,D1,SPA,2'd0,2'd0, 1'b1,64'h100,D1, 1'b1,1'b0,1'b0,1'b0},
        '{1'b1,2'd3,5'd2,5'd3,5'd1, 64'h100,D1,SPA,2'd0,2'd0, 1'b0,64'h0,64'h0, 1'b1,1'b1,1'b0,1'b0},
        '{1'b0,2'd3,5'd0,5'd0,5'd1, 64'h200,64'h0,SPA,2'd0,2'd0, 1'b0,64'h0,64'h0, 1'b0,1'b0,1'b0,1'b0},
        '{1'b1,2'd2,5'd2,5'd3,5'd1, 64'h204,D2,SPA,2'd0,2'd2, 1'b1,64'h204,64'h0000_0000_CCCC_DDDD, 1'b1,1'b0,1'b0,1'b0},
        '{1'b0,2'd2,5'd0,5'd0,5'd1, 64'h300,64'h0,SPA,2'd0,2'd0, 1'b0,64'h0,64'h0, 1'b0,1'b0,1'b0,1'b0},
        '{1'b1,2'd3,5'd2,5'd3,5'd1, 64'h300,D1,SPA,2'd0,2'd0, 1'b0,64'h0,64'h0, 1'b1,1'b1,1'b0,1'b0},
        '{1'b0,2'd3,5'd0,5'd0,5'd31, 64'h0,64'h0,SPA,2'd0,2'd0, 1'b0,64'h0,64'h0, 1'b0,1'b0,1'b0,1'b0},
        '{1'b1,2'd3,5'd2,5'd3,5'd31, 64'h0,D1,SPA,2'd0,2'd1, 1'b1,SPA,D1, 1'b1,1'b0,1'b0,1'b0},
        '{1'b0,2'd3,5'd0,5'd0,5'd5, 64'h400,64'h0,SPA,2'd0,2'd0, 1'b0,64'h0,64'h0, 1'b0,1'b0,1'b0,1'b0},
        '{1'b1,2'd3,5'd2,5'd3,5'd31, 64'h0,D1,64'h1008,2'd0,2'd0, 1'b0,64'h0,64'h0, 1'b0,1'b0,1'b1,1'b0},
        '{1'b1,2'd3,5'd2,5'd3,5'd5, 64'h400,D2,SPA,2'd0,2'd0, 1'b1,64'h400,D2, 1'b1,1'b0,1'b0,1'b0},
        '{1'b0,2'd3,5'd0,5'd0,5'd5, 64'h500,64'h0,SPA,2'd0,2'd0, 1'b0,64'h0,64'h0, 1'b0,1'b0,1'b0,1'b0},
        '{1'b1,2'd3,5'd3,5'd3,5'd5, 64'h500,D1,SPA,2'd1,2'd0, 1'b0,64'h0,64'h0, 1'b0,1'b0,1'b0,1'b1},
        '{1'b1,2'd3,5'd3,5'd3,5'd5, 64'h500,D1,SPA,2'd2,2'd0, 1'b0,64'h0,64'h0, 1'b0,1'b0,1'b0,1'b0},
        '{1'b1,2'd3,5'd3,5'd3,5'd5, 64'h500,D1,SPA,2'd0,2'd0, 1'b1,64'h500,64'h0, 1'b1,1'b0,1'b0,1'b0},
        '{1'b0,2'd3,5'd0,5'd0,5'd5, 64'h0,64'h0,SPA,2'd0,2'd0, 1'b0,64'h0,64'h0, 1'b0,1'b0,1'b0,1'b0},
        '{1'b1,2'd3,5'd5,5'd2,5'd5, 64'h900,D1,SPA,2'd0,2'd0, 1'b1,64'h0,D1, 1'b1,1'b0,1'b0,1'b0},
        '{1'b1,2'd3,5'd31,5'd2,5'd31, 64'h0,D1,SPA,2'd1,2'd0, 1'b0,64'h0,64'h0, 1'b1,1'b1,1'b0,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic        op_is_store = 1'b0;
    logic [1:0]  op_size = 2'd3;
    logic [4:0]  op_rs = '0;
    logic [4:0]  op_rt = '0;
    logic [4:0]  op_rn = '0;
    logic [63:0] rn_data = '0;
    logic [63:0] rt_data = '0;
    logic [63:0] sp_value = '0;
    logic [1:0]  overlap_mode = '0;
    logic        mon_clear = 1'b0;
    logic        busy;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b0;
    logic [63:0] mem_wr_addr;
    logic [63:0] mem_wr_data;
    logic [3:0]  mem_wr_bytes;
    logic        mem_wr_release;
    logic        mem_wr_tagchk;
    logic        st_we;
    logic [4:0]  st_idx;
    logic [31:0] st_val;
    logic        fault_align;
    logic        fault_undef;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xstore_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_is_store(op_is_store),
        .op_size(op_size), .op_rs(op_rs), .op_rt(op_rt), .op_rn(op_rn),
        .rn_data(rn_data), .rt_data(rt_data), .sp_value(sp_value),
        .overlap_mode(overlap_mode), .mon_clear(mon_clear), .busy(busy),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_bytes(mem_wr_bytes), .mem_wr_release(mem_wr_release),
        .mem_wr_tagchk(mem_wr_tagchk), .st_we(st_we), .st_idx(st_idx),
        .st_val(st_val), .fault_align(fault_align), .fault_undef(fault_undef)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input logic clr);
        logic saw_wr = 1'b0, saw_st = 1'b0, fa = 1'b0, fu = 1'b0;
        logic [63:0] wa = '0, wd = '0;
        logic [3:0]  wb = '0;
        logic        wtag = 1'b0, wrel = 1'b0, busy_ok = 1'b1;
        logic [31:0] sv = '0;
        logic [4:0]  si = '0;
        int hs_k = -1, st_k = -1, wcnt = 0;
        @(negedge clk);
        op_is_store = v.st; op_size = v.sz; op_rs = v.s; op_rt = v.t; op_rn = v.n;
        rn_data = v.base; rt_data = v.data; sp_value = v.sp; overlap_mode = v.mode;
        op_valid = 1'b1; mon_clear = clr;
        @(negedge clk);
        op_valid = 1'b0; mon_clear = 1'b0;
        for (int k = 0; k < 12; k++) begin
            if (mem_wr_valid) begin
                if (!saw_wr) begin
                    wa = mem_wr_addr; wd = mem_wr_data; wb = mem_wr_bytes;
                    wtag = mem_wr_tagchk; wrel = mem_wr_release;
                end
                saw_wr = 1'b1;
                if (!busy) busy_ok = 1'b0;
                if (mem_wr_addr !== wa || mem_wr_data !== wd) busy_ok = 1'b0;
                if (wcnt == int'(v.dly)) begin
                    mem_wr_ready = 1'b1;
                    hs_k = k;
                end
                wcnt++;
            end
            if (st_we) begin
                saw_st = 1'b1; st_k = k; sv = st_val; si = st_idx;
            end
            if (fault_align) fa = 1'b1;
            if (fault_undef) fu = 1'b1;
            @(negedge clk);
            mem_wr_ready = 1'b0;
        end
        chk(v.st ? "R3 R4 write issued" : "R2 load makes no write", 64'(saw_wr), 64'(v.ewr));
        chk(v.st ? "R4 status written" : "R2 load makes no status", 64'(saw_st), 64'(v.est));
        chk("R7 alignment fault", 64'(fa), 64'(v.efa));
        chk("R8 undefined fault", 64'(fu), 64'(v.efu));
        if (v.ewr && saw_wr) begin
            chk("R9 R7 R3 write address", wa, v.eaddr);
            chk("R1 R8 write data", wd, v.edata);
            chk("R1 byte count", 64'(wb), 64'(4'd1 << v.sz));
            chk("R10 tag check", 64'(wtag), 64'(v.n != 5'd31));
            chk("R10 release", 64'(wrel), 64'd1);
            chk("R11 held and busy", 64'(busy_ok), 64'd1);
            chk("R11 handshake cycle", 64'(hs_k), 64'(v.dly));
            chk("R3 status after handshake", 64'(st_k), 64'(hs_k + 1));
        end
        if (v.est && saw_st) begin
            chk("R5 status value", 64'(sv), {32'h0, 31'h0, v.estv});
            chk("R5 status index", 64'(si), 64'(v.s));
            if (v.estv) chk("R4 fail status timing", 64'(st_k), 64'd0);
        end
    endtask

    initial begin
        for (int c = 0; c < 50000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL R11 watchdog actual=timeout expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset busy", 64'(busy), 64'd0);
        chk("R11 reset write valid", 64'(mem_wr_valid), 64'd0);
        chk("R5 reset status strobe", 64'(st_we), 64'd0);
        chk("R7 reset faults", 64'({fault_align, fault_undef}), 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], 1'b0);
        end

        // R6: a clear pulse between load and store drops the reservation
        v = VECS[0];
        v.base = 64'h700;
        run_vec(v, 1'b0);
        @(negedge clk); mon_clear = 1'b1;
        @(negedge clk); mon_clear = 1'b0;
        v = VECS[2];
        v.base = 64'h700;
        run_vec(v, 1'b0);

        // R6: clear in the same cycle as a load leaves nothing armed
        v = VECS[0];
        v.base = 64'h780;
        run_vec(v, 1'b1);
        v = VECS[2];
        v.base = 64'h780;
        run_vec(v, 1'b0);

        // R2 R3: a word reservation then a matching word store succeeds
        v = VECS[5];
        v.base = 64'h800;
        run_vec(v, 1'b0);
        v = VECS[4];
        v.base = 64'h800; v.eaddr = 64'h800; v.dly = 2'd3;
        run_vec(v, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule